// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address used by a synchronous memory during a burst of four accesses. When a burst opens, the full external address is captured. After that, each advance request moves the two least significant address bits to the next position in the burst. The bits above them do not change. If neither a new burst nor an advance is requested, the position stays where it is.

A static mode input picks the order in which the four positions are visited. Interleaved order XORs the captured low bits with the beat number. Linear order adds the beat number to the captured low bits, modulo four.

Two address strobes can open a burst, and they are qualified differently. The processor-side strobe counts only while the chip-select qualifier is active. The controller-side strobe counts on its own. Every input is sampled on the rising clock edge. The output address is a combinational function of the captured address, the beat counter and the mode pin.

The controller has three states:
- **IDLE**: entered at reset. No burst has opened yet, so advance requests have no effect.
- **RUN**: a burst is open and stepping.
- **PAUSE**: a burst is open and suspended.

Its transitions are:
- **open**: from any state to RUN, on a burst start.
- **step**: from RUN or PAUSE to RUN, on an advance.
- **stall**: from RUN or PAUSE to PAUSE, when both strobes and the advance input are inactive.
- **wait**: IDLE stays in IDLE on anything other than a start.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cur_addr` reads 0.
- R2: A low `proc_strb_n` together with a low `chip_sel_n` at a rising edge captures `ext_addr`. From that edge on, `cur_addr` equals `ext_addr` in either mode.
- R3: A low `ctrl_strb_n` at a rising edge captures `ext_addr` whatever the level of `chip_sel_n`.
- R4: While `chip_sel_n` is high, a low `proc_strb_n` is ignored. The edge then acts as if that strobe were high: the address steps if `adv_n` is low and holds if `adv_n` is high.
- R5: With `burst_mode` = 1 (interleaved), beats 1, 2 and 3 give the captured address with bits 1:0 XORed by 01, 10 and 11 respectively.
- R6: With `burst_mode` = 0 (linear), bits 1:0 increase by one per beat modulo 4. A start at 10 gives 10, 11, 00, 01.
- R7: Bits above 1:0 keep their captured value for the whole burst. Advances past the fourth beat wrap within the same four-word group.
- R8: With both strobes high and `adv_n` high, the burst is suspended and `cur_addr` is held.
- R9: Before the first burst start after reset, advance requests leave `cur_addr` at 0.
- R10: A burst start takes priority over a simultaneous low `adv_n`. The new address is captured at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External address captured at a burst start |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, qualified by chip select |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low, unqualified |
| adv_n | input | 1 | Advance request, active low |
| chip_sel_n | input | 1 | Chip-select qualifier for the processor strobe, active low |
| burst_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| cur_addr | output | ADDR_W | Current internal burst address |

## Verification
The bench targets the following corner cases:
- **Start offsets.** Bursts start at non-zero low bits in both modes. A design that always counts up from 00, or that applies the wrong order, shows the wrong second and third beats.
- **Wrap past the fourth beat.** A burst runs beyond four advances. A carry leaking into bit 2 would change the upper address, and a counter that saturates would freeze the address.
- **Gated processor strobe.** The processor strobe is pulsed while chip select is inactive. A design that fails to gate it reloads the address.
- **Start versus advance.** A start arrives in the same cycle as an advance. Giving the advance priority leaves a stepped old address where the new one belongs.
- **Advances from IDLE.** Advances are sent before any burst has opened. An ungated counter would move the address away from zero.

// File: rtl/bas_pkg.sv
package bas_pkg;

    // Controller state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } seq_state_t;

    // Per-edge command decoded from the strobes
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } seq_cmd_t;

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
    import bas_pkg::*;
(
    input  logic     proc_strb_n,
    input  logic     ctrl_strb_n,
    input  logic     adv_n,
    input  logic     chip_sel_n,
    output seq_cmd_t cmd
);

    logic proc_start;
    logic ctrl_start;

    // Processor strobe counts only while the chip is selected.
    assign proc_start = ~proc_strb_n & ~chip_sel_n;
    assign ctrl_start = ~ctrl_strb_n;

    always_comb begin
        if (proc_start || ctrl_start) begin
            cmd = CMD_LOAD;
        end else if (!adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // R3
    always_comb begin
        if (ctrl_strb_n == 1'b0) begin
            ctrl_start_chk: assert (cmd == CMD_LOAD);
        end
    end

    // R4
    always_comb begin
        if (chip_sel_n == 1'b1 && ctrl_strb_n == 1'b1 && proc_strb_n == 1'b0) begin
            gated_proc_chk: assert (cmd != CMD_LOAD);
        end
    end

    // R10
    always_comb begin
        if (adv_n == 1'b0 && (ctrl_strb_n == 1'b0 || (proc_strb_n == 1'b0 && chip_sel_n == 1'b0))) begin
            start_wins_chk: assert (cmd == CMD_LOAD);
        end
    end

endmodule

// File: rtl/bas_order_gen.sv
module bas_order_gen #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] base_low,
    input  logic [LOW_W-1:0] beat,
    input  logic             interleave,
    output logic [LOW_W-1:0] offset
);

    logic [LOW_W-1:0] xor_pos;
    logic [LOW_W-1:0] add_pos;

    assign xor_pos = base_low ^ beat;
    assign add_pos = base_low + beat;

    always_comb begin
        unique case (interleave)
            1'b1:    offset = xor_pos;
            default: offset = add_pos;
        endcase
    end

    // R2: beat 0 presents the captured low bits in either order
    always_comb begin
        if (beat == '0) begin
            first_beat_chk: assert (offset == base_low);
        end
    end

endmodule

// File: rtl/bas_ctrl_fsm.sv
module bas_ctrl_fsm
    import bas_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_cmd_t          cmd,
    input  logic [ADDR_W-1:0] ext_addr,
    output seq_state_t        state_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q
);

    seq_state_t        state_d;
    logic [ADDR_W-1:0] base_d;
    logic [BEAT_W-1:0] beat_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd == CMD_LOAD) state_d = ST_RUN;          // open
            end
            ST_RUN, ST_PAUSE: begin
                unique case (cmd)
                    CMD_LOAD: state_d = ST_RUN;                  // open
                    CMD_STEP: state_d = ST_RUN;                  // step
                    default:  state_d = ST_PAUSE;                // stall
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath next values
    always_comb begin
        base_d = base_q;
        beat_d = beat_q;
        if (cmd == CMD_LOAD) begin
            base_d = ext_addr;
            beat_d = '0;
        end else if (cmd == CMD_STEP && state_q != ST_IDLE) begin
            beat_d = beat_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_d;
            beat_q <= beat_d;
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_LOAD |=> (base_q == $past(ext_addr)) && (beat_q == '0));

    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && state_q != ST_IDLE) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HOLD && state_q != ST_IDLE) |=> $stable(beat_q) && $stable(base_q));

    // R9
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd != CMD_LOAD) |=> state_q == ST_IDLE && beat_q == '0);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              chip_sel_n,
    input  logic              burst_mode,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int LOW_W = $clog2(BURST_LEN);

    seq_cmd_t          cmd;
    seq_state_t        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [LOW_W-1:0]  beat_q;
    logic [LOW_W-1:0]  offset;

    bas_cmd_decode u_dec (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .chip_sel_n  (chip_sel_n),
        .cmd         (cmd)
    );

    bas_ctrl_fsm #(
        .ADDR_W (ADDR_W),
        .BEAT_W (LOW_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .state_q  (state_q),
        .base_q   (base_q),
        .beat_q   (beat_q)
    );

    bas_order_gen #(
        .LOW_W (LOW_W)
    ) u_ord (
        .base_low   (base_q[LOW_W-1:0]),
        .beat       (beat_q),
        .interleave (burst_mode),
        .offset     (offset)
    );

    generate
        if (ADDR_W > LOW_W) begin : g_upper
            assign cur_addr = {base_q[ADDR_W-1:LOW_W], offset};
        end else begin : g_low_only
            assign cur_addr = offset;
        end
    endgenerate

    // R7
    group_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cmd != CMD_LOAD) |=> cur_addr[ADDR_W-1:LOW_W] == $past(cur_addr[ADDR_W-1:LOW_W]));

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          proc_strb_n;
    logic          ctrl_strb_n;
    logic          adv_n;
    logic          chip_sel_n;
    logic          burst_mode;
    logic [AW-1:0] cur_addr;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference model state
    logic          m_active;
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr    (ext_addr),
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .chip_sel_n  (chip_sel_n),
        .burst_mode  (burst_mode),
        .cur_addr    (cur_addr)
    );

    task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cur_addr=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected address
    task automatic drive(input logic p_n, input logic c_n, input logic a_n, input logic cs_n,
                         input logic md, input logic [AW-1:0] addr, input string tag);
        logic [1:0] low;
        @(negedge clk);
        proc_strb_n = p_n;
        ctrl_strb_n = c_n;
        adv_n       = a_n;
        chip_sel_n  = cs_n;
        burst_mode  = md;
        ext_addr    = addr;
        if ((!p_n && !cs_n) || !c_n) begin
            m_base   = addr;
            m_beat   = 2'd0;
            m_active = 1'b1;
        end else if (m_active && !a_n) begin
            m_beat = m_beat + 2'd1;
        end
        low = md ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        exp_q.push_back({m_base[AW-1:2], low});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                check(cur_addr, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        m_active    = 1'b0;
        m_base      = '0;
        m_beat      = 2'd0;
        rst_n       = 1'b0;
        proc_strb_n = 1'b1;
        ctrl_strb_n = 1'b1;
        adv_n       = 1'b1;
        chip_sel_n  = 1'b1;
        burst_mode  = 1'b1;
        ext_addr    = '0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check(cur_addr, '0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(cur_addr, '0, "R1 after reset");

        // R9: advances from IDLE do nothing
        drive(1, 1, 0, 0, 1, 15'h0003, "R9 idle advance");
        drive(1, 1, 0, 1, 0, 15'h0002, "R9 idle advance");

        // R2 + R5 interleaved from low bits 01
        drive(0, 1, 1, 0, 1, 15'h1235, "R2 proc start");
        drive(1, 1, 0, 0, 1, 15'h7FFF, "R5 beat1");
        drive(1, 1, 0, 0, 1, 15'h0000, "R5 beat2");
        drive(1, 1, 0, 0, 1, 15'h0000, "R5 beat3");
        drive(1, 1, 0, 0, 1, 15'h0000, "R7 wrap beat4");
        drive(1, 1, 0, 0, 1, 15'h0000, "R7 wrap beat5");

        // R8: suspend
        drive(1, 1, 1, 0, 1, 15'h5555, "R8 hold");
        drive(1, 1, 1, 1, 1, 15'h5555, "R8 hold");

        // R4: processor strobe gated by chip select
        drive(0, 1, 1, 1, 1, 15'h6666, "R4 gated proc hold");
        drive(0, 1, 0, 1, 1, 15'h6666, "R4 gated proc steps");

        // R3 + R6 linear from low bits 10, chip select inactive
        drive(1, 0, 1, 1, 0, 15'h2A06, "R3 ctrl start");
        drive(1, 1, 0, 1, 0, 15'h0000, "R6 beat1");
        drive(1, 1, 0, 1, 0, 15'h0000, "R6 beat2");
        drive(1, 1, 0, 1, 0, 15'h0000, "R6 beat3");
        drive(1, 1, 0, 1, 0, 15'h0000, "R7 linear wrap");
        drive(1, 1, 0, 1, 0, 15'h0000, "R7 linear wrap");

        // R10: start beats advance, upper-bit carry boundary
        drive(1, 0, 0, 1, 0, 15'h7FFF, "R10 ctrl start wins");
        drive(1, 1, 0, 1, 0, 15'h0000, "R7 no carry");
        drive(0, 1, 0, 0, 1, 15'h4003, "R10 proc start wins");
        drive(1, 1, 0, 0, 1, 15'h0000, "R5 from 11");

        // Mixed pattern
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3] | lfsr[4], lfsr[5] & lfsr[6],
                  lfsr[7], lfsr[8], {lfsr[14:0] ^ lfsr[15:1]}, "R7 mixed");
        end

        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule